// File: doc/BRIEF.md
# Serial audio ADC deserializer

This block turns the serial sample stream of an audio converter into parallel words. The converter uses short-pulse frame framing. The block runs entirely on the system clock. A separate strobe marks each falling edge of the bit clock, and every bit slot corresponds to one such strobe. A frame-sync input marks the slot that opens a frame. The sixteen slots after it carry one sample, most significant bit first. The block takes those sixteen bits and ignores every later slot of the frame.

When the last of the sixteen bits has been taken, the assembled word appears on the output register and a valid flag is raised for one system clock cycle. The word then stays unchanged until the next sample completes. A frame-sync strobe that arrives while a word is still being collected discards the partial word and starts a fresh count.

Top module: `audio_rx_deser`

## Requirements
- R1: A captured word holds the sixteen bits taken after the frame-sync slot, the first bit taken in bit 15 and the last in bit 0.
- R2: The valid output is high for exactly one clock cycle, the cycle right after the clock edge at which the strobe carrying the sixteenth bit is sampled, and never on two consecutive cycles.
- R3: Frame sync is acted on only in cycles where the strobe is high; that strobe is the sync slot and takes no data, and the first data bit is taken on the next strobe. Frame-sync levels in cycles without a strobe have no effect.
- R4: The serial input is sampled only in cycles where the strobe is high; its value in any other cycle has no effect on the word.
- R5: After the sixteenth bit the block takes no more bits and raises no valid until a strobe finds frame sync high again, whatever the serial input does.
- R6: A strobe with frame sync high while a word is in progress drops the partial word and restarts the count at zero; this applies on the strobe that would have carried the sixteenth bit too, in which case no word is produced for that frame.
- R7: Reset clears the word output to zero and the valid output to zero; between valid pulses the word output keeps its value.
- R8: Back-to-back frames of 64 slots, each opened by one sync slot, give exactly one word per frame, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe per bit slot (bit clock falling edge) |
| frame_start | input | 1 | Frame sync; high during the slot that opens a frame |
| ser_in | input | 1 | Serial sample data from the converter |
| word_out | output | 16 | Last completed sample word |
| word_valid | output | 1 | One-cycle flag marking a new word on word_out |

## Verification
The two functions that can meet in one cycle are word completion and restart: a frame-sync strobe can land exactly on the slot that would carry the sixteenth bit. The bench provokes this by opening a frame, sending fifteen data bits and then placing the next frame's sync slot where the sixteenth bit belongs. The scoreboard expects no word from the cut-off frame and the complete word of the following frame. Any valid pulse the queue does not expect is a failure.

// File: rtl/adrx_pkg.sv
package adrx_pkg;

  typedef enum logic {
    ADRX_IDLE = 1'b0,
    ADRX_CAPT = 1'b1
  } adrx_state_e;

  // True when the bit index addresses the final bit of a word.
  function automatic logic is_final(input int unsigned idx, input int unsigned width);
    return idx == (width - 1);
  endfunction

endpackage

// File: rtl/adrx_seq.sv
module adrx_seq
  import adrx_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic frame_start,
  output logic shift_en,
  output logic restart,
  output logic last_bit,
  output logic busy
);

  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  adrx_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  // Sync on a strobe opens a new word; restart wins over a data bit.
  assign restart  = bit_en & frame_start;
  assign shift_en = bit_en & ~frame_start & (state_q == ADRX_CAPT);
  assign last_bit = shift_en & is_final(32'(cnt_q), WORD_W);
  assign busy     = (state_q == ADRX_CAPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ADRX_IDLE;
      cnt_q   <= '0;
    end else if (restart) begin
      state_q <= ADRX_CAPT;
      cnt_q   <= '0;
    end else if (shift_en) begin
      if (last_bit) begin
        state_q <= ADRX_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/adrx_shift.sv
module adrx_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              ser_in,
  output logic [WORD_W-1:0] next_word
);

  localparam int unsigned HIST_W = WORD_W - 1;

  logic [HIST_W-1:0] hist_q;

  // Older bits sit higher; the incoming bit lands at position 0.
  function automatic logic [WORD_W-1:0] append_bit(input logic [HIST_W-1:0] h,
                                                   input logic b);
    return {h, b};
  endfunction

  assign next_word = append_bit(hist_q, ser_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (clear) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= next_word[HIST_W-1:0];
    end
  end

endmodule

// File: rtl/adrx_out.sv
module adrx_out #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] next_word,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= load;
      if (load) begin
        word_out <= next_word;
      end
    end
  end

endmodule

// File: rtl/audio_rx_deser.sv
module audio_rx_deser #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_start,
  input  logic              ser_in,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);

  // Named internal events, also used by the bound checker.
  logic              shift_en;
  logic              restart;
  logic              last_bit;
  logic              busy;
  logic [WORD_W-1:0] next_word;

  adrx_seq #(.WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .frame_start (frame_start),
    .shift_en    (shift_en),
    .restart     (restart),
    .last_bit    (last_bit),
    .busy        (busy)
  );

  adrx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (restart),
    .shift_en  (shift_en),
    .ser_in    (ser_in),
    .next_word (next_word)
  );

  adrx_out #(.WORD_W(WORD_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (last_bit),
    .next_word  (next_word),
    .word_out   (word_out),
    .word_valid (word_valid)
  );

endmodule

// File: rtl/adrx_chk.sv
module adrx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic              frame_start,
  input logic              last_bit,
  input logic              busy,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid
);

  p_one_cycle_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  p_valid_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> word_valid);

  p_valid_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(last_bit));

  p_state_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(busy));

  p_idle_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(bit_en && frame_start)) |=> (!busy && !word_valid));

  p_restart_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_start) |=> (busy && !word_valid));

  p_word_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_out));

endmodule

bind audio_rx_deser adrx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .frame_start (frame_start),
  .last_bit    (last_bit),
  .busy        (busy),
  .word_out    (word_out),
  .word_valid  (word_valid)
);

// File: tb/audio_rx_deser_bench.sv
module audio_rx_deser_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic        frame_start;
  logic        ser_in;
  logic [15:0] word_out;
  logic        word_valid;

  int          checks = 0;
  int          failures = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_word = 16'h0000;
  logic        prev_valid = 1'b0;
  bit          done = 1'b0;
  bit          reported = 1'b0;

  always #10 clk = ~clk;

  audio_rx_deser u_audio_rx_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .frame_start (frame_start),
    .ser_in      (ser_in),
    .word_out    (word_out),
    .word_valid  (word_valid)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  // Monitor: pops the scoreboard on each valid, checks hold otherwise.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_valid && word_valid)
        check(1'b0, "R2 valid wider than one cycle", 16'h1, 16'h0);
      if (word_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5/R6 unexpected word", word_out, 16'h0);
        end else begin
          check(word_out == exp_q[0], "R1 captured word", word_out, exp_q[0]);
          void'(exp_q.pop_front());
        end
        last_word = word_out;
      end else begin
        check(word_out == last_word, "R7 word hold", word_out, last_word);
      end
      prev_valid = word_valid;
    end
  end

  // One bit slot: three quiet cycles carrying noise, then the strobe.
  task automatic slot(input bit fs, input bit b, input bit noise);
    for (int i = 0; i < 3; i++) begin
      bit_en      = 1'b0;
      ser_in      = ~b;
      frame_start = noise ? ~fs : 1'b0;
      @(negedge clk);
    end
    bit_en      = 1'b1;
    ser_in      = b;
    frame_start = fs;
    @(negedge clk);
    bit_en      = 1'b0;
    frame_start = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input bit noise);
    exp_q.push_back(w);
    slot(1'b1, 1'b0, noise);
    for (int i = 15; i >= 0; i--) slot(1'b0, w[i], noise);
  endtask

  task automatic idle_slots(input int n);
    for (int i = 0; i < n; i++) slot(1'b0, i[0] ^ i[2], 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; frame_start = 1'b0; ser_in = 1'b0;
    repeat (5) @(negedge clk);
    check(word_out == 16'h0000, "R7 reset word", word_out, 16'h0000);
    check({15'd0, word_valid} == 16'h0, "R7 reset valid", {15'd0, word_valid}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R8: plain 64-slot frames back to back.
    send_word(16'hA5C3, 1'b0); idle_slots(47);
    // R3 R4: noise on data and sync outside strobe cycles.
    send_word(16'h8001, 1'b1); idle_slots(47);
    send_word(16'h7FFE, 1'b0); idle_slots(47);

    // R6: sync after seven bits restarts the count.
    slot(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) slot(1'b0, 1'b1, 1'b0);
    send_word(16'h1234, 1'b0); idle_slots(20);

    // R6: sync lands on the sixteenth-bit slot; no word for that frame.
    slot(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) slot(1'b0, 1'b1, 1'b0);
    send_word(16'h0F0F, 1'b0); idle_slots(20);

    // R5: long stretch with data but no sync must stay silent.
    idle_slots(70);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all words delivered", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule